// File: doc/BRIEF.md
# NAND Flash Cycle Sequencer

This block runs NAND flash bus cycles from a queue of 32-bit command words. A host or DMA engine loads the words into an internal eight-entry queue. The sequencer takes the words one at a time, only when it is idle. Each word states one kind of bus cycle: an address latch, a command latch, a burst of data writes or a burst of data reads. The sequencer then drives the flash control pins for that cycle, with strobe widths set by parameters.

Bytes for write bursts arrive on a byte-wide stream input. Bytes from read bursts leave on a byte-wide stream output. Each word also carries three control bits:
- a wait-for-ready bit, which holds completion until the flash ready/busy line goes high again;
- a last-cycle bit, which releases chip enable once the word finishes;
- an interrupt bit, which raises an interrupt pulse alongside the completion pulse.

A whole flash operation, such as command, address, data and confirm, can therefore be queued and run with no processor involvement.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are high. nand_cle, nand_ale, nand_io_oe, op_done, op_irq, op_err and tx_ready are low. The queue reports empty and not full.
- R2: Bits 17:16 of a word select the cycle type. Value 0 is an address cycle: ALE high with WE# strobes. Value 1 is a command cycle: CLE high with WE# strobes. Value 2 is a data write: WE# strobes with CLE and ALE low. Value 3 is a data read: RE# strobes with the I/O bus not driven.
- R3: A command or address word gives exactly one WE# strobe, and drives bits 7:0 of the word onto nand_io_out.
- R4: A data word gives exactly (bits 11:0) + 1 strobes.
- R5: Each strobe is low for exactly T_LOW clocks. Between strobes the line stays high for at least T_HIGH clocks.
- R6: Each write strobe carries the next byte accepted from the tx stream, in order. An accept happens when tx_valid and tx_ready are both high. No write strobe starts while the byte for it has not arrived.
- R7: Read data is captured from nand_io_in at the clock edge where RE# returns high. It is presented on rx_data together with a one-cycle rx_valid.
- R8: nand_ce_n goes low when a word is taken from an idle queue. It stays low across the following words. It goes high only after a word with bit 18 set completes. No strobe occurs while nand_ce_n is high.
- R9: When bit 19 is set, the word's strobes are followed by a wait of T_WB clocks. After that, completion waits for nand_rb to be high. op_done follows in the clock after nand_rb is seen high.
- R10: If nand_rb stays low for RDY_TIMEOUT clocks during a ready wait, the word completes with op_err pulsed together with op_done.
- R11: op_done pulses for one clock per completed word. op_irq pulses with it only when bit 13 of that word is set.
- R12: The queue holds DEPTH words. It raises cmd_full when it has DEPTH entries and cmd_empty when it has none. A push while full is dropped. Words run in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_push | input | 1 | Write cmd_data into the queue |
| cmd_data | input | 32 | Command word |
| cmd_full | output | 1 | Queue full |
| cmd_empty | output | 1 | Queue empty |
| tx_data | input | 8 | Byte to write to flash |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Sequencer takes tx_data this cycle if valid |
| rx_data | output | 8 | Byte read from flash |
| rx_valid | output | 1 | rx_data valid for one cycle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus output value |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus input value |
| nand_rb | input | 1 | Ready (1) / busy (0) |
| op_done | output | 1 | Word completed |
| op_irq | output | 1 | Completion interrupt for words with bit 13 set |
| op_err | output | 1 | Ready wait timed out |

## Verification
The two functions that can meet in one cycle are queue filling and sequencer execution. The bench provokes this by holding back tx_valid while a write word is running. That stalls the sequencer while eight more command words are pushed, so the queue reaches full and a ninth push falls on a full queue. When the stream is released, the bench judges the case from the flash pins: exactly eight command strobes must follow the three write strobes, carrying bytes 0x10 to 0x17 in order, and the dropped byte must never appear. The ready wait is judged to the exact cycle: the bench records when it releases nand_rb and requires op_done one clock later.

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
  parameter int DEPTH       = 8,
  parameter int T_LOW       = 2,
  parameter int T_HIGH      = 2,
  parameter int T_WB        = 4,
  parameter int RDY_TIMEOUT = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_push,
  input  logic [31:0] cmd_data,
  output logic        cmd_full,
  output logic        cmd_empty,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb,
  output logic        op_done,
  output logic        op_irq,
  output logic        op_err
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LEN_W = 12;
  localparam int MAXC  = RDY_TIMEOUT + T_LOW + T_HIGH + T_WB;
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [1:0] TY_ADDR = 2'd0;
  localparam logic [1:0] TY_CMD  = 2'd1;
  localparam logic [1:0] TY_WR   = 2'd2;
  localparam logic [1:0] TY_RD   = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_LO, S_HI, S_WB, S_RDY, S_DONE} st_t;

  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [PTR_W:0]   count;
  logic [31:0]      head;
  logic             push, pop;

  st_t              state;
  logic [1:0]       ty;
  logic             f_wfr, f_last, f_iwc;
  logic [7:0]       f_byte;
  logic [LEN_W-1:0] left;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       wbyte;
  logic             ce_q, timed_out, busy;
  logic             unused_bits;

  assign head      = mem[rp];
  assign cmd_full  = (count == (PTR_W+1)'(DEPTH));
  assign cmd_empty = (count == '0);
  assign push      = cmd_push && !cmd_full;
  assign pop       = (state == S_IDLE) && !cmd_empty;
  assign unused_bits = &{1'b0, head[31:20], head[15:14], head[12]};

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= cmd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ty        <= TY_ADDR;
      f_wfr     <= 1'b0;
      f_last    <= 1'b0;
      f_iwc     <= 1'b0;
      f_byte    <= '0;
      left      <= '0;
      cnt       <= '0;
      wbyte     <= '0;
      ce_q      <= 1'b1;
      timed_out <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        S_IDLE: if (pop) begin
          ty        <= head[17:16];
          f_wfr     <= head[19];
          f_last    <= head[18];
          f_iwc     <= head[13];
          f_byte    <= head[7:0];
          left      <= head[17] ? head[LEN_W-1:0] : '0;
          cnt       <= '0;
          ce_q      <= 1'b0;
          timed_out <= 1'b0;
          state     <= (head[17:16] == TY_WR) ? S_TX : S_LO;
        end
        S_TX: if (tx_valid) begin
          wbyte <= tx_data;
          cnt   <= '0;
          state <= S_LO;
        end
        S_LO: begin
          if (cnt == CNT_W'(T_LOW-1)) begin
            cnt   <= '0;
            state <= S_HI;
            if (ty == TY_RD) begin
              rx_valid <= 1'b1;
              rx_data  <= nand_io_in;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_HI: begin
          if (cnt == CNT_W'(T_HIGH-1)) begin
            cnt <= '0;
            if (left != '0) begin
              left  <= left - 1'b1;
              state <= (ty == TY_WR) ? S_TX : S_LO;
            end else if (f_wfr) state <= S_WB;
            else                state <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_WB: begin
          if (cnt == CNT_W'(T_WB-1)) begin
            cnt   <= '0;
            state <= S_RDY;
          end else cnt <= cnt + 1'b1;
        end
        S_RDY: begin
          if (nand_rb) state <= S_DONE;
          else if (cnt == CNT_W'(RDY_TIMEOUT-1)) begin
            timed_out <= 1'b1;
            state     <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_DONE: begin
          if (f_last) ce_q <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign nand_ce_n   = ce_q;
  assign nand_cle    = busy && (ty == TY_CMD);
  assign nand_ale    = busy && (ty == TY_ADDR);
  assign nand_we_n   = !((state == S_LO) && (ty != TY_RD));
  assign nand_re_n   = !((state == S_LO) && (ty == TY_RD));
  assign nand_io_oe  = busy && (ty != TY_RD);
  assign nand_io_out = (ty == TY_WR) ? wbyte : f_byte;
  assign tx_ready    = (state == S_TX);
  assign op_done     = (state == S_DONE);
  assign op_irq      = op_done && f_iwc;
  assign op_err      = op_done && timed_out;

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_ce_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  assert_rx_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (nand_re_n && $past(!nand_re_n)));
  assert_ready_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && f_wfr && !op_err) |-> $past(nand_rb));
  assert_irq_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_irq |-> op_done);
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push && cmd_full && !pop) |=> $stable(count));
  assert_bus_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
endmodule

// File: tb/nand_cycle_seq_tb_top.sv
module nand_cycle_seq_tb_top;
  localparam int TL = 2, TH = 3, TWB = 4, TMO = 30;

  logic clk = 0, rst_n = 0;
  logic cmd_push = 0;
  logic [31:0] cmd_data = '0;
  logic cmd_full, cmd_empty;
  logic [7:0] tx_data;
  logic tx_valid = 1;
  logic tx_ready;
  logic [7:0] rx_data;
  logic rx_valid;
  logic ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0] io_out;
  logic [7:0] io_in = '0;
  logic rb = 1;
  logic done, irq, err;

  always #5 clk = ~clk;

  nand_cycle_seq #(.DEPTH(8), .T_LOW(TL), .T_HIGH(TH), .T_WB(TWB), .RDY_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_data(cmd_data),
    .cmd_full(cmd_full), .cmd_empty(cmd_empty), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .nand_ce_n(ce_n),
    .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in), .nand_rb(rb),
    .op_done(done), .op_irq(irq), .op_err(err));

  int tests = 0, fails = 0;
  int cyc = 0, tx_cnt = 0;
  int nw = 0, nr = 0, nrx = 0, rx_bad = 0, ndone = 0, nirq = 0, nerr = 0, nce_rise = 0;
  int lo_len = 0, hi_len = 100, lo_bad = 0, hi_bad = 0, ce_bad = 0, done_cyc = 0;
  logic pw = 1, pr = 1, pce = 1;
  logic [7:0] wlog [256];
  logic       wcle [256];
  logic       wale [256];

  assign tx_data = 8'(8'hA0 + tx_cnt);

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] mkw(int t, bit wfr, bit last, bit iwc, int low);
    return (32'(wfr) << 19) | (32'(last) << 18) | (32'(t) << 16) | (32'(iwc) << 13) | 32'(low & 12'hFFF);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_ready && tx_valid) tx_cnt <= tx_cnt + 1;
  end

  always @(negedge clk) if (rst_n) begin
    if ((!we_n || !re_n) && ce_n) ce_bad++;
    if (!we_n || !re_n) lo_len++;
    else hi_len++;
    if ((!we_n && pw) || (!re_n && pr)) begin
      if (hi_len < TH) hi_bad++;
      hi_len = 0;
      lo_len = 1;
      if (!re_n) io_in = pat(nr);
    end
    if (we_n && !pw) begin
      if (lo_len != TL) lo_bad++;
      wlog[nw & 255] = io_out; wcle[nw & 255] = cle; wale[nw & 255] = ale;
      nw++;
    end
    if (re_n && !pr) begin
      if (lo_len != TL) lo_bad++;
      nr++;
    end
    if (rx_valid) begin
      if (rx_data != pat(nrx)) rx_bad++;
      nrx++;
    end
    if (done) begin ndone++; done_cyc = cyc; end
    if (irq) nirq++;
    if (err) nerr++;
    if (ce_n && !pce) nce_rise++;
    pw = we_n; pr = re_n; pce = ce_n;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w);
    cmd_push = 1; cmd_data = w;
    @(negedge clk);
    cmd_push = 0;
  endtask

  task automatic wait_done(int n);
    int g = 0;
    while (ndone < n && g < 3000) begin @(posedge clk); g++; end
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base, d0, i0, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ce_n && we_n && re_n, "R1 strobes/ce idle high", {ce_n, we_n, re_n}, 7);
    chk(!cle && !ale && !io_oe && !tx_ready, "R1 latch/oe low", {cle, ale, io_oe, tx_ready}, 0);
    chk(!done && !irq && !err, "R1 status low", {done, irq, err}, 0);
    chk(cmd_empty && !cmd_full, "R1 queue empty", {cmd_empty, cmd_full}, 2);

    // R2 R3 R7 R8: command, address, read burst as one operation
    base = nw; d0 = ndone; i0 = nirq;
    push(mkw(1, 0, 0, 0, 8'h90));
    push(mkw(0, 0, 0, 0, 8'h00));
    push(mkw(3, 0, 1, 1, 4));
    wait_done(d0 + 3);
    chk(nw - base == 2, "R3 one strobe per cmd/addr", nw - base, 2);
    chk(wcle[base & 255] && !wale[base & 255] && wlog[base & 255] == 8'h90, "R2 R3 command cycle", wlog[base & 255], 8'h90);
    chk(!wcle[(base+1) & 255] && wale[(base+1) & 255] && wlog[(base+1) & 255] == 8'h00, "R2 R3 address cycle", wale[(base+1) & 255], 1);
    chk(nrx == 5 && rx_bad == 0, "R7 read bytes", nrx, 5);
    chk(nce_rise == 1 && ce_n, "R8 ce held across op", nce_rise, 1);
    chk(nirq - i0 == 1, "R11 irq on flagged word", nirq - i0, 1);

    // R4 R6 write sweep (no irq), R4 R7 read sweep (irq)
    for (int len = 1; len <= 8; len++) begin
      int tx0;
      base = nw; d0 = ndone; i0 = nirq; tx0 = tx_cnt; bad = 0;
      push(mkw(2, 0, 1, 0, len - 1));
      wait_done(d0 + 1);
      for (int k = 0; k < len; k++)
        if (wlog[(base + k) & 255] !== 8'(8'hA0 + tx0 + k) || wcle[(base + k) & 255] || wale[(base + k) & 255]) bad++;
      chk(nw - base == len, "R4 write strobe count", nw - base, len);
      chk(bad == 0 && tx_cnt - tx0 == len, "R6 write bytes in order", bad, 0);
      chk(nirq == i0, "R11 no irq without flag", nirq - i0, 0);
    end
    for (int len = 1; len <= 8; len++) begin
      int r0;
      r0 = nrx; d0 = ndone; i0 = nirq;
      push(mkw(3, 0, 1, 1, len - 1));
      wait_done(d0 + 1);
      chk(nrx - r0 == len && rx_bad == 0, "R4 R7 read count/data", nrx - r0, len);
      chk(nirq - i0 == 1, "R11 irq per flagged word", nirq - i0, 1);
    end

    // R6 stall and R12 full/drop
    tx_valid = 0;
    base = nw; d0 = ndone;
    push(mkw(2, 0, 1, 0, 2));
    repeat (20) @(negedge clk);
    chk(nw == base && tx_ready, "R6 no strobe without data", nw - base, 0);
    for (int i = 0; i < 8; i++) push(mkw(1, 0, 1, 0, 8'h10 + i));
    chk(cmd_full && !cmd_empty, "R12 queue full at depth", cmd_full, 1);
    push(mkw(1, 0, 1, 0, 8'h77));
    tx_valid = 1;
    wait_done(d0 + 9);
    repeat (20) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 8; i++)
      if (wlog[(base + 3 + i) & 255] !== 8'(8'h10 + i) || !wcle[(base + 3 + i) & 255]) bad++;
    chk(nw - base == 11, "R12 dropped push not run", nw - base, 11);
    chk(bad == 0, "R12 order kept", bad, 0);
    chk(cmd_empty && ndone == d0 + 9, "R11 R12 one done per word", ndone - d0, 9);

    // R9 wait for ready
    base = nw; d0 = ndone;
    push(mkw(1, 1, 1, 0, 8'h30));
    while (nw == base) @(posedge clk);
    @(negedge clk); rb = 0;
    repeat (12) @(negedge clk);
    begin
      int rel;
      rel = cyc; rb = 1;
      wait_done(d0 + 1);
      chk(done_cyc == rel + 1, "R9 done one clock after ready", done_cyc, rel + 1);
    end
    chk(nerr == 0, "R9 no error on normal wait", nerr, 0);

    // R10 timeout
    base = nw; d0 = ndone;
    push(mkw(1, 1, 1, 0, 8'hD0));
    while (nw == base) @(posedge clk);
    @(negedge clk); rb = 0;
    wait_done(d0 + 1);
    chk(nerr == 1 && ndone == d0 + 1, "R10 timeout error", nerr, 1);
    rb = 1;

    chk(lo_bad == 0, "R5 strobe low width", lo_bad, 0);
    chk(hi_bad == 0, "R5 strobe high width", hi_bad, 0);
    chk(ce_bad == 0, "R8 no strobe with ce high", ce_bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule